// File: doc/BRIEF.md
# VGA Register File Emulator

This block answers byte-wide host I/O cycles aimed at the classic VGA register window, 0x3C0 through 0x3DA. It keeps the register state a display adapter's initialisation code expects to find. That state covers the attribute, sequencer, graphics and CRT register banks, each reached through an index register with a bounds check. It also holds the miscellaneous output byte, the pixel mask, the colour palette with its read and write pointers, and a status byte that changes on every read. No pixels or timing are produced. The block exists so that setup code which programs these registers runs correctly and reads back the values it expects.

The host presents a port address with a read or write strobe for one cycle. Read data is registered and appears on the cycle after the strobe, then holds until the next read. A 16-bit write is accepted as one request and is applied over two cycles: the low byte goes to the addressed port and the high byte goes to the next port up.

Top module: `vga_regfile_emu`

## Requirements
- R1: After reset every index register, both palette pointers, the attribute flip-flop, the miscellaneous output byte, the pixel mask, the status byte and the read data are zero.
- R2: Port 0x3C0 acts as the attribute index while the flip-flop is 0 and as attribute data at that index while it is 1. Every read and every write of 0x3C0 inverts the flip-flop.
- R3: Attribute data is reached only when the attribute index is below 21. Otherwise a data write is dropped and a data read returns 0xFF. Port 0x3C1 reads attribute data without touching the flip-flop, and writes to 0x3C1 are dropped.
- R4: The miscellaneous output byte is written at 0x3C2 and read at 0x3CC. A read of 0x3C2 returns 0xFF.
- R5: 0x3C4 holds the sequencer index and 0x3C5 reaches sequencer data while the index is below 5. Outside that range, data writes are dropped and data reads return 0xFF. 0x3C6 is a plain read/write pixel mask byte.
- R6: A write of v to 0x3C7 sets the palette read pointer to 3*v, and a write of v to 0x3C8 sets the write pointer to 3*v. Reading 0x3C7 or 0x3C8 returns bits 7:0 of the matching pointer.
- R7: A read of 0x3C9 returns the palette byte at the read pointer and then advances that pointer. A write to 0x3C9 stores at the write pointer and then advances it. At 768 or above, reads return 0xFF, writes are dropped and neither pointer moves.
- R8: 0x3CE holds the graphics index and 0x3CF reaches graphics data while the index is below 9. Out-of-range data writes are dropped and data reads return 0xFF.
- R9: The CRT index at 0x3D4 and CRT data at 0x3D5 are reachable only while bit 0 of the miscellaneous output byte is 1. Data also requires an index below 25. Blocked writes are dropped and blocked reads return 0xFF.
- R10: A read of 0x3DA returns the status byte, then XORs the stored byte with 0x09 and clears the attribute flip-flop. Writes to 0x3DA are dropped.
- R11: A read of any port not listed above returns 0xFF, and a write to such a port changes nothing.
- R12: When the word flag is set with a write, the low byte is applied to the port in that cycle and the high byte to port+1 in the next cycle. Any request presented in that second cycle is dropped.
- R13: Read data changes only on the clock edge that ends a read cycle. If read and write are both asserted, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_port | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_word | input | 1 | With io_wr: 16-bit write split over port and port+1 |
| io_wdata | input | 16 | Write data; bits 15:8 used only for word writes |
| io_rdata | output | 8 | Registered read data, valid the cycle after io_rd |

## Verification
A wrong flip-flop state shows on the very next 0x3C0 read: an index value comes back where data was expected, or the reverse. Every later 0x3C0 access stays misaligned until a 0x3DA read realigns it. A palette pointer that is off by one shifts every later palette byte read, so an error made when the pointer is loaded shows within one read. A status byte that fails to toggle, or a lost CRT gate, shows on the next read of 0x3DA or 0x3D4/0x3D5. The bench therefore tracks all of this state in a model and compares every read immediately.

// File: rtl/vga_emu_pkg.sv
package vga_emu_pkg;

    localparam int PORT_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int ATTR_REGS   = 21;
    localparam int SEQ_REGS    = 5;
    localparam int GFX_REGS    = 9;
    localparam int CRT_REGS    = 25;
    localparam int PAL_BYTES   = 768;
    localparam int PAL_PTR_W   = $clog2(PAL_BYTES + 1);

    localparam logic [BYTE_W-1:0] NO_DATA     = 8'hFF;
    localparam logic [BYTE_W-1:0] STAT_FLIP   = 8'h09;

    typedef enum logic [3:0] {
        P_NONE,
        P_ATTR,      // shared index/data
        P_ATTR_RD,   // data read-only view
        P_MISC_W,
        P_MISC_R,
        P_SEQ_I,
        P_SEQ_D,
        P_MASK,
        P_DAC_RI,
        P_DAC_WI,
        P_DAC_D,
        P_GFX_I,
        P_GFX_D,
        P_CRT_I,
        P_CRT_D,
        P_STAT
    } vport_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [PORT_W-1:0] port;
        logic [BYTE_W-1:0] data;
    } vacc_t;

    function automatic vport_e decode_port(input logic [PORT_W-1:0] p);
        case (p)
            16'h03C0: return P_ATTR;
            16'h03C1: return P_ATTR_RD;
            16'h03C2: return P_MISC_W;
            16'h03CC: return P_MISC_R;
            16'h03C4: return P_SEQ_I;
            16'h03C5: return P_SEQ_D;
            16'h03C6: return P_MASK;
            16'h03C7: return P_DAC_RI;
            16'h03C8: return P_DAC_WI;
            16'h03C9: return P_DAC_D;
            16'h03CE: return P_GFX_I;
            16'h03CF: return P_GFX_D;
            16'h03D4: return P_CRT_I;
            16'h03D5: return P_CRT_D;
            16'h03DA: return P_STAT;
            default:  return P_NONE;
        endcase
    endfunction

endpackage

// File: rtl/vga_port_decode.sv
module vga_port_decode
    import vga_emu_pkg::*;
(
    input  logic [PORT_W-1:0] port,
    output vport_e            kind
);
    always_comb kind = decode_port(port);
endmodule

// File: rtl/vga_idx_bank.sv
module vga_idx_bank #(
    parameter int COUNT = 21,
    parameter int DW    = 8,
    parameter int IW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] idx,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          hit
);
    localparam int SEL_W = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [IW:0] LIM = (IW+1)'(COUNT);

    logic [DW-1:0] regs [COUNT];
    logic [SEL_W-1:0] sel;

    assign hit   = {1'b0, idx} < LIM;
    assign sel   = idx[SEL_W-1:0];
    assign rdata = hit ? regs[sel] : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < COUNT; i++) regs[i] <= '0;
        end else if (we && hit) begin
            regs[sel] <= wdata;
        end
    end
endmodule

// File: rtl/vga_dac_pal.sv
module vga_dac_pal #(
    parameter int BYTES = 768,
    parameter int PW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_rd,
    input  logic          ld_wr,
    input  logic [DW-1:0] ld_val,
    input  logic          d_rd,
    input  logic          d_wr,
    input  logic [DW-1:0] wdata,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] wr_ptr,
    output logic [DW-1:0] rdata
);
    localparam logic [PW-1:0] LIM = PW'(BYTES);

    logic [DW-1:0] mem [BYTES];
    logic [PW-1:0] ld3;
    logic          rd_ok, wr_ok;

    assign ld3   = (PW'(ld_val) << 1) + PW'(ld_val);
    assign rd_ok = rd_ptr < LIM;
    assign wr_ok = wr_ptr < LIM;
    assign rdata = rd_ok ? mem[rd_ptr] : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            if (ld_rd)            rd_ptr <= ld3;
            else if (d_rd && rd_ok) rd_ptr <= rd_ptr + 1'b1;
            if (ld_wr)            wr_ptr <= ld3;
            else if (d_wr && wr_ok) wr_ptr <= wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (d_wr && wr_ok) mem[wr_ptr] <= wdata;
    end

    // R7: a palette read in range advances the read pointer by one
    a_r7_rd_step: assert property (@(posedge clk) disable iff (rst)
        (d_rd && !ld_rd && rd_ok) |=> rd_ptr == $past(rd_ptr) + 1'b1);
    // R7: neither pointer passes the palette end
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr <= LIM) && (wr_ptr <= LIM));
    // R7: a write at the end leaves the write pointer parked
    a_r7_wr_parked: assert property (@(posedge clk) disable iff (rst)
        (d_wr && !ld_wr && !wr_ok) |=> $stable(wr_ptr));
    // R6: pointer load scales by three
    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        ld_wr |=> wr_ptr == PW'($past(ld_val)) * PW'(3));
endmodule

// File: rtl/vga_regfile_emu.sv
module vga_regfile_emu
    import vga_emu_pkg::*;
#(
    parameter int N_ATTR = ATTR_REGS,
    parameter int N_SEQ  = SEQ_REGS,
    parameter int N_GFX  = GFX_REGS,
    parameter int N_CRT  = CRT_REGS,
    parameter int N_PAL  = PAL_BYTES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_port,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic        io_word,
    input  logic [15:0] io_wdata,
    output logic [7:0]  io_rdata
);
    localparam int PW = $clog2(N_PAL + 1);

    vacc_t             acc;
    vport_e            kind;
    logic              pend_v;
    logic [PORT_W-1:0] pend_port;
    logic [BYTE_W-1:0] pend_data;

    logic              attr_ff;
    logic [7:0]        attr_idx, seq_idx, gfx_idx, crt_idx;
    logic [7:0]        misc_q, mask_q, status_q;
    logic [7:0]        rd_val;

    logic [7:0]        attr_rd, seq_rd, gfx_rd, crt_rd, pal_rd;
    logic              attr_hit, seq_hit, gfx_hit, crt_hit;
    logic [PW-1:0]     pal_rp, pal_wp;
    logic              crt_open;

    // access selection: a pending high byte preempts the host
    always_comb begin
        if (pend_v) begin
            acc.rd   = 1'b0;
            acc.wr   = 1'b1;
            acc.port = pend_port;
            acc.data = pend_data;
        end else begin
            acc.rd   = io_rd & ~io_wr;
            acc.wr   = io_wr;
            acc.port = io_port;
            acc.data = io_wdata[7:0];
        end
    end

    assign crt_open = misc_q[0];

    vga_port_decode u_dec (.port(acc.port), .kind(kind));

    vga_idx_bank #(.COUNT(N_ATTR)) u_attr (
        .clk(clk), .rst(rst), .idx(attr_idx),
        .we(acc.wr && kind == P_ATTR && attr_ff),
        .wdata(acc.data), .rdata(attr_rd), .hit(attr_hit));

    vga_idx_bank #(.COUNT(N_SEQ)) u_seq (
        .clk(clk), .rst(rst), .idx(seq_idx),
        .we(acc.wr && kind == P_SEQ_D),
        .wdata(acc.data), .rdata(seq_rd), .hit(seq_hit));

    vga_idx_bank #(.COUNT(N_GFX)) u_gfx (
        .clk(clk), .rst(rst), .idx(gfx_idx),
        .we(acc.wr && kind == P_GFX_D),
        .wdata(acc.data), .rdata(gfx_rd), .hit(gfx_hit));

    vga_idx_bank #(.COUNT(N_CRT)) u_crt (
        .clk(clk), .rst(rst), .idx(crt_idx),
        .we(acc.wr && kind == P_CRT_D && crt_open),
        .wdata(acc.data), .rdata(crt_rd), .hit(crt_hit));

    vga_dac_pal #(.BYTES(N_PAL), .PW(PW)) u_pal (
        .clk(clk), .rst(rst),
        .ld_rd(acc.wr && kind == P_DAC_RI),
        .ld_wr(acc.wr && kind == P_DAC_WI),
        .ld_val(acc.data),
        .d_rd(acc.rd && kind == P_DAC_D),
        .d_wr(acc.wr && kind == P_DAC_D),
        .wdata(acc.data),
        .rd_ptr(pal_rp), .wr_ptr(pal_wp), .rdata(pal_rd));

    // read multiplexer (bank outputs already give 0xFF out of range)
    always_comb begin
        rd_val = NO_DATA;
        case (kind)
            P_ATTR:    rd_val = attr_ff ? attr_rd : attr_idx;
            P_ATTR_RD: rd_val = attr_rd;
            P_MISC_R:  rd_val = misc_q;
            P_SEQ_I:   rd_val = seq_idx;
            P_SEQ_D:   rd_val = seq_rd;
            P_MASK:    rd_val = mask_q;
            P_DAC_RI:  rd_val = pal_rp[7:0];
            P_DAC_WI:  rd_val = pal_wp[7:0];
            P_DAC_D:   rd_val = pal_rd;
            P_GFX_I:   rd_val = gfx_idx;
            P_GFX_D:   rd_val = gfx_rd;
            P_CRT_I:   rd_val = crt_open ? crt_idx : NO_DATA;
            P_CRT_D:   rd_val = crt_open ? crt_rd : NO_DATA;
            P_STAT:    rd_val = status_q;
            default:   rd_val = NO_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_port <= '0;
            pend_data <= '0;
            attr_ff   <= 1'b0;
            attr_idx  <= '0;
            seq_idx   <= '0;
            gfx_idx   <= '0;
            crt_idx   <= '0;
            misc_q    <= '0;
            mask_q    <= '0;
            status_q  <= '0;
            io_rdata  <= '0;
        end else begin
            pend_v <= 1'b0;
            if (!pend_v && io_wr && io_word) begin
                pend_v    <= 1'b1;
                pend_port <= io_port + 16'd1;
                pend_data <= io_wdata[15:8];
            end
            if (acc.rd) begin
                io_rdata <= rd_val;
                if (kind == P_ATTR) attr_ff <= ~attr_ff;
                if (kind == P_STAT) begin
                    attr_ff  <= 1'b0;
                    status_q <= status_q ^ STAT_FLIP;
                end
            end
            if (acc.wr) begin
                case (kind)
                    P_ATTR: begin
                        if (!attr_ff) attr_idx <= acc.data;
                        attr_ff <= ~attr_ff;
                    end
                    P_MISC_W: misc_q  <= acc.data;
                    P_SEQ_I:  seq_idx <= acc.data;
                    P_MASK:   mask_q  <= acc.data;
                    P_GFX_I:  gfx_idx <= acc.data;
                    P_CRT_I:  if (crt_open) crt_idx <= acc.data;
                    default: ;
                endcase
            end
        end
    end

    // R2: every 0x3C0 access inverts the flip-flop
    a_r2_ff_toggle: assert property (@(posedge clk) disable iff (rst)
        ((acc.rd || acc.wr) && kind == P_ATTR) |=> attr_ff != $past(attr_ff));
    // R10: status read clears the flip-flop
    a_r10_ff_clear: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && kind == P_STAT) |=> !attr_ff);
    // R10: status read flips bits 0 and 3
    a_r10_stat_flip: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && kind == P_STAT) |=> status_q == ($past(status_q) ^ 8'h09));
    // R9: CRT index frozen while the gate is closed
    a_r9_crt_gate: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && kind == P_CRT_I && !crt_open) |=> $stable(crt_idx));
    // R12: a word write always schedules its high byte
    a_r12_split: assert property (@(posedge clk) disable iff (rst)
        (!pend_v && io_wr && io_word) |=> pend_v);
    // R13: read data holds outside read cycles
    a_r13_hold: assert property (@(posedge clk) disable iff (rst)
        !acc.rd |=> $stable(io_rdata));
endmodule

// File: tb/vga_regfile_emu_bench.sv
module vga_regfile_emu_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] io_port;
    logic        io_rd, io_wr, io_word;
    logic [15:0] io_wdata;
    logic [7:0]  io_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    vga_regfile_emu u_vga_regfile_emu (
        .clk(clk), .rst(rst), .io_port(io_port), .io_rd(io_rd),
        .io_wr(io_wr), .io_word(io_word), .io_wdata(io_wdata),
        .io_rdata(io_rdata));

    // ---------------- reference model ----------------
    bit       m_ff;
    int       m_aidx, m_sidx, m_gidx, m_cidx, m_rp, m_wp;
    logic [7:0] m_attr [21];
    logic [7:0] m_seq  [5];
    logic [7:0] m_gfx  [9];
    logic [7:0] m_crt  [25];
    logic [7:0] m_pal  [768];
    bit         m_pk   [768];
    logic [7:0] m_misc, m_mask, m_stat;

    task automatic model_reset();
        m_ff = 0; m_aidx = 0; m_sidx = 0; m_gidx = 0; m_cidx = 0;
        m_rp = 0; m_wp = 0; m_misc = 0; m_mask = 0; m_stat = 0;
        foreach (m_attr[i]) m_attr[i] = 0;
        foreach (m_seq[i])  m_seq[i]  = 0;
        foreach (m_gfx[i])  m_gfx[i]  = 0;
        foreach (m_crt[i])  m_crt[i]  = 0;
    endtask

    task automatic model_wr(input logic [15:0] p, input logic [7:0] d);
        case (p)
            16'h3C0: begin
                if (!m_ff) m_aidx = d;
                else if (m_aidx < 21) m_attr[m_aidx] = d;
                m_ff = !m_ff;
            end
            16'h3C2: m_misc = d;
            16'h3C4: m_sidx = d;
            16'h3C5: if (m_sidx < 5) m_seq[m_sidx] = d;
            16'h3C6: m_mask = d;
            16'h3C7: m_rp = d * 3;
            16'h3C8: m_wp = d * 3;
            16'h3C9: if (m_wp < 768) begin m_pal[m_wp] = d; m_pk[m_wp] = 1; m_wp++; end
            16'h3CE: m_gidx = d;
            16'h3CF: if (m_gidx < 9) m_gfx[m_gidx] = d;
            16'h3D4: if (m_misc[0]) m_cidx = d;
            16'h3D5: if (m_misc[0] && m_cidx < 25) m_crt[m_cidx] = d;
            default: ;
        endcase
    endtask

    task automatic model_rd(input logic [15:0] p, output logic [7:0] e, output bit known);
        known = 1;
        e = 8'hFF;
        case (p)
            16'h3C0: begin
                if (!m_ff) e = 8'(m_aidx);
                else if (m_aidx < 21) e = m_attr[m_aidx];
                m_ff = !m_ff;
            end
            16'h3C1: if (m_aidx < 21) e = m_attr[m_aidx];
            16'h3CC: e = m_misc;
            16'h3C4: e = 8'(m_sidx);
            16'h3C5: if (m_sidx < 5) e = m_seq[m_sidx];
            16'h3C6: e = m_mask;
            16'h3C7: e = 8'(m_rp);
            16'h3C8: e = 8'(m_wp);
            16'h3C9: if (m_rp < 768) begin e = m_pal[m_rp]; known = m_pk[m_rp]; m_rp++; end
            16'h3CE: e = 8'(m_gidx);
            16'h3CF: if (m_gidx < 9) e = m_gfx[m_gidx];
            16'h3D4: if (m_misc[0]) e = 8'(m_cidx);
            16'h3D5: if (m_misc[0] && m_cidx < 25) e = m_crt[m_cidx];
            16'h3DA: begin e = m_stat; m_ff = 0; m_stat ^= 8'h09; end
            default: ;
        endcase
    endtask

    function automatic string req_of(input logic [15:0] p);
        case (p)
            16'h3C0: return "R2";
            16'h3C1: return "R3";
            16'h3C2, 16'h3CC: return "R4";
            16'h3C4, 16'h3C5, 16'h3C6: return "R5";
            16'h3C7, 16'h3C8: return "R6";
            16'h3C9: return "R7";
            16'h3CE, 16'h3CF: return "R8";
            16'h3D4, 16'h3D5: return "R9";
            16'h3DA: return "R10";
            default: return "R11";
        endcase
    endfunction

    // ---------------- check and access tasks ----------------
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic acc_wr(input logic [15:0] p, input logic [7:0] d);
        @(negedge clk);
        io_port = p; io_wr = 1; io_word = 0; io_wdata = {8'h00, d};
        @(negedge clk);
        io_wr = 0;
        model_wr(p, d);
    endtask

    task automatic acc_wr16(input logic [15:0] p, input logic [15:0] d);
        @(negedge clk);
        io_port = p; io_wr = 1; io_word = 1; io_wdata = d;
        @(negedge clk);
        io_wr = 0; io_word = 0;
        model_wr(p, d[7:0]);
        model_wr(p + 16'd1, d[15:8]);
    endtask

    task automatic acc_rd(input logic [15:0] p, input string req);
        logic [7:0] e;
        bit k;
        @(negedge clk);
        io_port = p; io_rd = 1;
        @(negedge clk);
        io_rd = 0;
        model_rd(p, e, k);
        if (k) check(req, io_rdata, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    localparam logic [15:0] PLIST [18] = '{
        16'h3C0, 16'h3C1, 16'h3C2, 16'h3C3, 16'h3C4, 16'h3C5, 16'h3C6,
        16'h3C7, 16'h3C8, 16'h3C9, 16'h3CC, 16'h3CE, 16'h3CF, 16'h3D4,
        16'h3D5, 16'h3DA, 16'h3DB, 16'h3CA };

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        rst = 1; io_port = 0; io_rd = 0; io_wr = 0; io_word = 0; io_wdata = 0;
        foreach (m_pk[i]) m_pk[i] = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        check("R1", io_rdata, 8'h00);
        acc_rd(16'h3C4, "R1");
        acc_rd(16'h3CC, "R1");
        acc_rd(16'h3C8, "R1");
        acc_rd(16'h3DA, "R1");
        // R10: toggled status
        acc_rd(16'h3DA, "R10");
        check("R10", io_rdata, 8'h09);

        // R2/R3: index/data alternation and bounds
        acc_wr(16'h3C0, 8'h04); acc_wr(16'h3C0, 8'h5A);
        acc_rd(16'h3C1, "R3"); check("R3", io_rdata, 8'h5A);
        acc_rd(16'h3C0, "R2"); check("R2", io_rdata, 8'h04);
        acc_rd(16'h3C0, "R2"); check("R2", io_rdata, 8'h5A);
        acc_wr(16'h3C0, 8'd21); acc_wr(16'h3C0, 8'h33);
        acc_rd(16'h3C1, "R3"); check("R3", io_rdata, 8'hFF);
        acc_wr(16'h3C1, 8'h77);
        acc_wr(16'h3C0, 8'h04);
        acc_rd(16'h3DA, "R10");          // clears flip-flop
        acc_rd(16'h3C0, "R10");          // index view again
        check("R10", io_rdata, 8'h04);

        // R4: misc and its write port read
        acc_wr(16'h3C2, 8'h00);
        acc_rd(16'h3C2, "R4"); check("R4", io_rdata, 8'hFF);

        // R9: CRT gate closed
        acc_wr(16'h3D4, 8'h05);
        acc_rd(16'h3D4, "R9"); check("R9", io_rdata, 8'hFF);
        acc_wr(16'h3C2, 8'h01);
        acc_rd(16'h3D4, "R9"); check("R9", io_rdata, 8'h00);
        acc_wr(16'h3D4, 8'd24); acc_wr(16'h3D5, 8'hC3);
        acc_rd(16'h3D5, "R9"); check("R9", io_rdata, 8'hC3);
        acc_wr(16'h3D4, 8'd25);
        acc_rd(16'h3D5, "R9"); check("R9", io_rdata, 8'hFF);

        // R6/R7: palette end corner
        acc_wr(16'h3C8, 8'd255);
        acc_rd(16'h3C8, "R6"); check("R6", io_rdata, 8'hFD);
        for (int i = 0; i < 4; i++) acc_wr(16'h3C9, 8'(8'h10 + i));
        acc_rd(16'h3C8, "R7"); check("R7", io_rdata, 8'h00);
        acc_wr(16'h3C7, 8'd255);
        for (int i = 0; i < 4; i++) acc_rd(16'h3C9, "R7");
        check("R7", io_rdata, 8'hFF);
        acc_wr(16'h3C8, 8'd2); acc_wr(16'h3C9, 8'hA1); acc_wr(16'h3C9, 8'hA2);
        acc_wr(16'h3C7, 8'd2); acc_rd(16'h3C9, "R7"); acc_rd(16'h3C9, "R7");
        check("R7", io_rdata, 8'hA2);

        // R8 and R11
        acc_wr(16'h3CE, 8'd8); acc_wr(16'h3CF, 8'h6E);
        acc_rd(16'h3CF, "R8"); check("R8", io_rdata, 8'h6E);
        acc_wr(16'h3CE, 8'd9); acc_rd(16'h3CF, "R8");
        acc_rd(16'h3C3, "R11"); acc_rd(16'h3DB, "R11");

        // R5 and R12: word write split, then a dropped request
        acc_wr16(16'h3C4, 16'hAB02);
        acc_rd(16'h3C5, "R12"); check("R12", io_rdata, 8'hAB);
        @(negedge clk);
        io_port = 16'h3C4; io_wr = 1; io_word = 1; io_wdata = 16'h0303;
        @(negedge clk);
        io_word = 0; io_wdata = 16'h0004;   // presented in the high-byte slot
        model_wr(16'h3C4, 8'h03); model_wr(16'h3C5, 8'h03);
        @(negedge clk);
        io_wr = 0;
        acc_rd(16'h3C4, "R12"); check("R12", io_rdata, 8'h03);

        // R13: hold across writes, write wins when both strobes set
        acc_rd(16'h3C6, "R13");
        held = io_rdata;
        acc_wr(16'h3C6, 8'h9C);
        check("R13", io_rdata, held);
        @(negedge clk);
        io_port = 16'h3C6; io_rd = 1; io_wr = 1; io_wdata = 16'h0042;
        @(negedge clk);
        io_rd = 0; io_wr = 0;
        model_wr(16'h3C6, 8'h42);
        check("R13", io_rdata, held);
        acc_rd(16'h3C6, "R5"); check("R5", io_rdata, 8'h42);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] p;
            logic [7:0]  d;
            int          kind;
            p = PLIST[$urandom_range(0, 17)];
            d = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 30))
                                            : 8'($urandom_range(0, 255));
            kind = $urandom_range(0, 9);
            if (kind < 5)       acc_rd(p, req_of(p));
            else if (kind < 9)  acc_wr(p, d);
            else                acc_wr16(p, {8'($urandom_range(0, 255)), d});
        end

        finish_run();
    end
endmodule